// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 9-bit words that sits between two unrelated clock domains. A producer pushes words on the write clock and a consumer pops them on the read clock. Four active-low status outputs report the fill level: empty and almost-empty are generated in the read domain, and full and almost-full in the write domain. The two "almost" thresholds come from two offset registers that software-free logic upstream can reprogram.

One dual-purpose input is captured while reset is held. If it is high, the block runs in dual-enable mode and that input acts as a second, active-high write enable. If it is low, the block runs in load mode. In load mode, pulling the same input low turns write-side accesses into writes of the offset registers and read-side accesses into read-backs of them. Both sequences visit the almost-empty register first and the almost-full register second, then wrap. The output bus is registered and can be released to high impedance.

Top module: `dcfifo_progflags`

## Requirements
- R1: While reset is held and just after it, emptyN is 0, fullN is 1, almostEmptyN is 0, almostFullN is 1, the output register holds 0, and both offsets hold 7.
- R2: In dual-enable mode a word is stored at a rising write-clock edge only when wrEnN is 0, wrEnBLoad is 1 and fullN is 1. An attempt with wrEnBLoad at 0, or while full, changes neither the contents nor the flags.
- R3: The level of wrEnBLoad during reset selects the mode (1 selects dual-enable, 0 selects load mode). The mode cannot change until the next reset.
- R4: In load mode, a rising write-clock edge with wrEnN at 0 and wrEnBLoad at 0 copies dataIn[3:0] into one offset register. The registers are taken in the order almost-empty, almost-full, and the order then wraps. With wrEnBLoad at 1 the same edge stores a data word, subject to full.
- R5: A word is popped at a rising read-clock edge only when rdEnAN and rdEnBN are both 0 and emptyN is 1, and it appears on the output register at that edge. Words leave in the order they were written. A pop request made while empty, or with only one read enable low, leaves the output and the flags unchanged.
- R6: In load mode, a rising read-clock edge with both read enables at 0 and wrEnBLoad at 0 places an offset, zero-extended, on the output register. A separate read-back pointer takes almost-empty first and almost-full second, and then wraps. No FIFO word is consumed.
- R7: emptyN is 0 exactly when the fill level is 0. fullN is 0 exactly when the level equals the depth (16 at default parameters).
- R8: almostEmptyN is 0 when the level is at most the almost-empty offset. almostFullN is 0 when the level is at least depth minus the almost-full offset.
- R9: With outEnN at 1 every bit of dataOut is high impedance. With outEnN at 0 dataOut drives the output register.
- R10: Pointers cross domains as gray code through two synchronizing flops. A push becomes visible on emptyN by the third falling read-clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| rstN | input | 1 | Active-low reset, asynchronous assert; both clocks must run while it is held |
| dataIn | input | 9 | Write data, and offset value in load mode |
| wrEnN | input | 1 | Active-low write enable |
| wrEnBLoad | input | 1 | Second write enable (dual mode) or active-low offset access select (load mode); sampled in reset |
| rdEnAN | input | 1 | First active-low read enable |
| rdEnBN | input | 1 | Second active-low read enable |
| outEnN | input | 1 | Active-low output enable |
| dataOut | output | 9 | Registered read data or offset read-back, tri-stated |
| emptyN | output | 1 | Low when empty, read domain |
| fullN | output | 1 | Low when full, write domain |
| almostEmptyN | output | 1 | Low when level is at or below the almost-empty offset |
| almostFullN | output | 1 | Low when level is at or above depth minus the almost-full offset |

## Verification
The bench fills the buffer one word at a time, from empty to full, and then drains it. It checks all four flags at every one of the seventeen levels, first with the default offsets and then with loaded offsets of 3 and 5. The two passes separate threshold arithmetic from hard-wired limits. Words with distinct arithmetic values show that ordering is preserved and that a write into a full buffer is discarded. Single-enable attempts and an empty read show that each enable is required. Interleaved offset loads and read-backs, including a third access in each domain, confirm the visiting order and the independent wrap of the two pointers.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;
  // strobes from control to datapath, one cycle wide in their own domain
  typedef struct packed {
    logic pushWord;    // write domain: store dataIn into the array
    logic loadOffset;  // write domain: store dataIn into an offset register
    logic loadSel;     // write domain: 0 = almost-empty, 1 = almost-full
    logic popWord;     // read domain: move array word to output register
    logic showOffset;  // read domain: move offset to output register
    logic showSel;     // read domain: 0 = almost-empty, 1 = almost-full
  } fifoStrobes_t;

  localparam int OFFSET_COUNT = 2;
endpackage

// File: rtl/fifo_ctrl.sv
`timescale 1ns/1ps
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic              wrEnBLoad,
  input  logic              rdEnAN,
  input  logic              rdEnBN,
  input  logic [ADDR_W-1:0] aeOffset,
  input  logic [ADDR_W-1:0] afOffset,
  output fifoStrobes_t      str,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyN,
  output logic              fullN,
  output logic              almostEmptyN,
  output logic              almostFullN
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

  // mode captured in each domain while reset is held
  logic modeLoadW, modeLoadR;
  always_ff @(posedge wrClk) if (!rstN) modeLoadW <= !wrEnBLoad;
  always_ff @(posedge rdClk) if (!rstN) modeLoadR <= !wrEnBLoad;

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrPtr, wrPtrNext, wrGray;
  logic [PTR_W-1:0] rdGraySyncA, rdGraySyncB, rdPtrInW, wrCount, afThresh;
  logic [PTR_W-1:0] rdPtr, rdPtrNext, rdGray;
  logic [PTR_W-1:0] wrGraySyncA, wrGraySyncB, wrPtrInR, rdCount;
  logic pushW, loadW, isFull, loadSel;
  logic popR, showR, isEmpty, showSel;

  always_comb begin
    for (int i = 0; i < PTR_W; i++) rdPtrInW[i] = ^(rdGraySyncB >> i);
    wrCount  = wrPtr - rdPtrInW;
    isFull   = (wrCount == FULL_CNT);
    afThresh = FULL_CNT - {1'b0, afOffset};
    pushW    = !wrEnN && wrEnBLoad && !isFull;
    loadW    = modeLoadW && !wrEnN && !wrEnBLoad;
    wrPtrNext = wrPtr + PTR_W'(pushW);
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr       <= '0;
      wrGray      <= '0;
      rdGraySyncA <= '0;
      rdGraySyncB <= '0;
      loadSel     <= 1'b0;
    end else begin
      wrPtr       <= wrPtrNext;
      wrGray      <= wrPtrNext ^ (wrPtrNext >> 1);
      rdGraySyncA <= rdGray;
      rdGraySyncB <= rdGraySyncA;
      if (loadW) loadSel <= !loadSel;
    end
  end

  // ---------------- read domain ----------------
  always_comb begin
    for (int i = 0; i < PTR_W; i++) wrPtrInR[i] = ^(wrGraySyncB >> i);
    rdCount   = wrPtrInR - rdPtr;
    isEmpty   = (rdCount == '0);
    showR     = modeLoadR && !rdEnAN && !rdEnBN && !wrEnBLoad;
    popR      = !rdEnAN && !rdEnBN && !isEmpty && !showR;
    rdPtrNext = rdPtr + PTR_W'(popR);
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr       <= '0;
      rdGray      <= '0;
      wrGraySyncA <= '0;
      wrGraySyncB <= '0;
      showSel     <= 1'b0;
    end else begin
      rdPtr       <= rdPtrNext;
      rdGray      <= rdPtrNext ^ (rdPtrNext >> 1);
      wrGraySyncA <= wrGray;
      wrGraySyncB <= wrGraySyncA;
      if (showR) showSel <= !showSel;
    end
  end

  always_comb begin
    str.pushWord   = pushW;
    str.loadOffset = loadW;
    str.loadSel    = loadSel;
    str.popWord    = popR;
    str.showOffset = showR;
    str.showSel    = showSel;
  end

  assign wrAddr       = wrPtr[ADDR_W-1:0];
  assign rdAddr       = rdPtr[ADDR_W-1:0];
  assign fullN        = !isFull;
  assign almostFullN  = !(wrCount >= afThresh);
  assign emptyN       = !isEmpty;
  assign almostEmptyN = !(rdCount <= {1'b0, aeOffset});

  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (!rstN) wrCount <= FULL_CNT); // R2
  AST_MODE_HELD: assert property (@(posedge wrClk) disable iff (!rstN) $stable(modeLoadW)); // R3
  AST_WR_GRAY_STEP: assert property (@(posedge wrClk) disable iff (!rstN) $onehot0(wrGray ^ $past(wrGray))); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (!rstN) rdCount <= FULL_CNT); // R5
  AST_RD_GRAY_STEP: assert property (@(posedge rdClk) disable iff (!rstN) $onehot0(rdGray ^ $past(rdGray))); // R10
endmodule

// File: rtl/fifo_data.sv
`timescale 1ns/1ps
module fifo_data
  import fifo_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int ADDR_W      = 4,
  parameter int OFF_DEFAULT = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobes_t      str,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic [ADDR_W-1:0] aeOffset,
  output logic [ADDR_W-1:0] afOffset
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] offReg [OFFSET_COUNT];
  logic [DATA_W-1:0] qReg;

  always_ff @(posedge wrClk) begin
    if (str.pushWord) mem[wrAddr] <= dataIn;
  end

  // index 0 = almost-empty, index 1 = almost-full
  for (genvar k = 0; k < OFFSET_COUNT; k++) begin : gOffset
    always_ff @(posedge wrClk or negedge rstN) begin
      if (!rstN) offReg[k] <= ADDR_W'(OFF_DEFAULT);
      else if (str.loadOffset && (str.loadSel == 1'(k))) offReg[k] <= dataIn[ADDR_W-1:0];
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) qReg <= '0;
    else if (str.popWord) qReg <= mem[rdAddr];
    else if (str.showOffset) qReg <= {{PAD_W{1'b0}}, offReg[str.showSel]};
  end

  assign aeOffset = offReg[0];
  assign afOffset = offReg[1];
  assign dataOut  = outEnN ? {DATA_W{1'bz}} : qReg;

  AST_SHOW_XOR_POP: assert property (@(posedge rdClk) disable iff (!rstN) !(str.popWord && str.showOffset)); // R6
  AST_LOAD_XOR_PUSH: assert property (@(posedge wrClk) disable iff (!rstN) !(str.pushWord && str.loadOffset)); // R4
endmodule

// File: rtl/dcfifo_progflags.sv
`timescale 1ns/1ps
module dcfifo_progflags
  import fifo_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int ADDR_W      = 4,
  parameter int OFF_DEFAULT = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              wrEnN,
  input  logic              wrEnBLoad,
  input  logic              rdEnAN,
  input  logic              rdEnBN,
  input  logic              outEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic              emptyN,
  output logic              fullN,
  output logic              almostEmptyN,
  output logic              almostFullN
);
  fifoStrobes_t      str;
  logic [ADDR_W-1:0] wrAddr, rdAddr, aeOffset, afOffset;

  fifo_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnN(wrEnN), .wrEnBLoad(wrEnBLoad), .rdEnAN(rdEnAN), .rdEnBN(rdEnBN),
    .aeOffset(aeOffset), .afOffset(afOffset),
    .str(str), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyN(emptyN), .fullN(fullN),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  fifo_data #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_DEFAULT(OFF_DEFAULT)) uData (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .str(str), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dataIn(dataIn), .outEnN(outEnN), .dataOut(dataOut),
    .aeOffset(aeOffset), .afOffset(afOffset)
  );
endmodule

// File: tb/dcfifo_progflags_test.sv
`timescale 1ns/1ps
module dcfifo_progflags_test;
  localparam int DEPTH = 16;

  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic [8:0] dataIn = '0;
  logic wrEnN = 1'b1, wrEnBLoad = 1'b1, rdEnAN = 1'b1, rdEnBN = 1'b1, outEnN = 1'b0;
  wire  [8:0] dOut;
  logic emptyN, fullN, almostEmptyN, almostFullN;
  int checks = 0, errors = 0;

  always #2.5 wrClk = ~wrClk;   // 200 MHz
  always #3.5 rdClk = ~rdClk;

  for (genvar i = 0; i < 9; i++) begin : gPull
    pullup (dOut[i]);
  end

  dcfifo_progflags uut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .dataIn(dataIn),
    .wrEnN(wrEnN), .wrEnBLoad(wrEnBLoad), .rdEnAN(rdEnAN), .rdEnBN(rdEnBN),
    .outEnN(outEnN), .dataOut(dOut), .emptyN(emptyN), .fullN(fullN),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  function automatic logic [8:0] wordAt(int i);
    return 9'((i * 37 + 5) & 9'h1ff);
  endfunction

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(logic pin);
    wrEnBLoad = pin; wrEnN = 1'b1; rdEnAN = 1'b1; rdEnBN = 1'b1;
    rstN = 1'b0;
    repeat (4) @(negedge wrClk);
    repeat (4) @(negedge rdClk);
    rstN = 1'b1;
    repeat (2) @(negedge wrClk);
  endtask

  task automatic settle();
    repeat (4) @(negedge rdClk);
    repeat (4) @(negedge wrClk);
  endtask

  task automatic push(logic [8:0] v);
    @(negedge wrClk); dataIn = v; wrEnN = 1'b0;
    @(negedge wrClk); wrEnN = 1'b1;
  endtask

  task automatic pop();
    @(negedge rdClk); rdEnAN = 1'b0; rdEnBN = 1'b0;
    @(negedge rdClk); rdEnAN = 1'b1; rdEnBN = 1'b1;
  endtask

  // expected flags from the level, arithmetic per R7 and R8
  task automatic flagsAt(int lvl, int ae, int af);
    chk("R7 emptyN", 9'(emptyN), 9'(lvl != 0));
    chk("R7 fullN", 9'(fullN), 9'(lvl != DEPTH));
    chk("R8 almostEmptyN", 9'(almostEmptyN), 9'(!(lvl <= ae)));
    chk("R8 almostFullN", 9'(almostFullN), 9'(!(lvl >= DEPTH - af)));
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // ---------- dual-enable mode ----------
    wrEnBLoad = 1'b1; rstN = 1'b0;
    repeat (2) @(negedge wrClk);
    chk("R1 emptyN in reset", 9'(emptyN), 9'd0);
    chk("R1 fullN in reset", 9'(fullN), 9'd1);
    doReset(1'b1);
    settle();
    flagsAt(0, 7, 7);                          // R1 defaults
    chk("R1 output register", dOut, 9'h000);

    // R10: visibility latency of a push on emptyN
    push(wordAt(0));
    repeat (3) @(negedge rdClk);
    chk("R10 emptyN after push", 9'(emptyN), 9'd1);
    settle();
    flagsAt(1, 7, 7);

    for (int i = 1; i < DEPTH; i++) begin      // R7 R8 fill sweep
      push(wordAt(i));
      settle();
      flagsAt(i + 1, 7, 7);
    end
    push(9'h1aa);                              // R2 write while full discarded
    settle();
    flagsAt(DEPTH, 7, 7);

    for (int i = 0; i < DEPTH; i++) begin      // R5 order, R7 R8 drain sweep
      pop();
      chk("R5 pop data", dOut, wordAt(i));
      settle();
      flagsAt(DEPTH - 1 - i, 7, 7);
    end
    pop();                                     // R5 pop while empty
    chk("R5 empty pop holds output", dOut, wordAt(DEPTH - 1));

    // R2: second enable low blocks the write
    @(negedge wrClk); wrEnBLoad = 1'b0; wrEnN = 1'b0; dataIn = 9'h0f0;
    @(negedge wrClk); wrEnN = 1'b1; wrEnBLoad = 1'b1;
    settle();
    chk("R2 write blocked by second enable", 9'(emptyN), 9'd0);

    // R5: a single read enable does not pop
    push(9'h055);
    settle();
    @(negedge rdClk); rdEnAN = 1'b0;
    @(negedge rdClk); rdEnAN = 1'b1;
    settle();
    chk("R5 single enable keeps word", 9'(emptyN), 9'd1);
    chk("R5 single enable keeps output", dOut, wordAt(DEPTH - 1));
    pop();
    chk("R5 pop after gate test", dOut, 9'h055);

    // R9: output enable
    @(negedge rdClk); outEnN = 1'b1;
    #1 chk("R9 released bus", dOut, 9'h1ff);
    outEnN = 1'b0;
    #1 chk("R9 driven bus", dOut, 9'h055);

    // ---------- load mode ----------
    doReset(1'b0);                             // R3 pin low in reset selects load mode
    settle();
    flagsAt(0, 7, 7);
    pop();
    chk("R6 readback default almost-empty", dOut, 9'd7);
    pop();
    chk("R6 readback default almost-full", dOut, 9'd7);
    push(9'h003);                              // R4 first load -> almost-empty
    push(9'h005);                              // R4 second load -> almost-full
    settle();
    chk("R4 loads store no word", 9'(emptyN), 9'd0);
    pop();
    chk("R6 readback almost-empty", dOut, 9'd3);
    pop();
    chk("R6 readback almost-full", dOut, 9'd5);
    pop();
    chk("R6 readback wraps", dOut, 9'd3);

    @(negedge wrClk); wrEnBLoad = 1'b1;        // R4 data writes in load mode
    settle();
    flagsAt(0, 3, 5);
    for (int i = 0; i < DEPTH; i++) begin      // R8 with loaded offsets
      push(wordAt(i + 20));
      settle();
      flagsAt(i + 1, 3, 5);
    end
    for (int i = 0; i < DEPTH; i++) begin
      pop();
      chk("R4 data in load mode", dOut, wordAt(i + 20));
      settle();
      flagsAt(DEPTH - 1 - i, 3, 5);
    end

    @(negedge wrClk); wrEnBLoad = 1'b0;
    push(9'h002);                              // R4 third load wraps to almost-empty
    settle();
    pop();                                     // read-back pointer sits on almost-full
    chk("R6 independent readback pointer", dOut, 9'd5);
    pop();
    chk("R4 load pointer wrapped", dOut, 9'd2);

    // R3: mode survives traffic; pin high still writes data
    @(negedge wrClk); wrEnBLoad = 1'b1;
    push(9'h111);
    settle();
    pop();
    chk("R3 mode held after reset", dOut, 9'h111);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule